// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a station-management master that reads and writes 16-bit PHY registers over a two-wire management bus. The host raises a one-cycle request carrying a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The controller then serialises a complete frame on MDC/MDIO. The MDIO pad is split into an output, an output enable and an input. The MDC rate is set by a half-period count that is taken at the moment the request is accepted.

A write frame drives a preamble followed by the full 32-bit command word. A read frame drives the preamble and the 14 command bits, then releases the line for a turnaround cycle. After that cycle it samples the PHY's acknowledge zero and shifts in 16 data bits. When the acknowledge is missing, the read result is all ones. Every frame finishes with one extra MDC low phase holding the last driven bit, and with one MDC cycle in which the line is released. A one-cycle done pulse then ends the busy period.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, done, mdc and mdio_oe are 0, and rdata is 0x0000.
- R2: Each MDC half period lasts half_div+1 system clocks. half_div is captured when a request is accepted, so later changes to it do not affect a frame already in progress.
- R3: Every frame starts with 32 one-bits driven on MDIO. Driven bits go out most significant bit first. Each bit is set up while MDC is low and stays stable while MDC is high.
- R4: A write frame drives 64 bits in total: the preamble, then start 01, opcode 01, PHY address, register address, turnaround 10 and wdata.
- R5: A read frame drives 46 bits in total: the preamble, then start 01, opcode 10, PHY address and register address. It then releases MDIO.
- R6: After the last driven bit, MDC stays low for one more half period. During that half period the last bit is held and mdio_oe stays 1.
- R7: A read then gives one released MDC cycle and samples the acknowledge at its end. It then samples 16 data bits, most significant first, each at the end of an MDC high phase. When the acknowledge was 0, rdata is set to those bits.
- R8: If the sampled acknowledge is 1, rdata becomes 0xFFFF.
- R9: Each frame ends with MDIO released for one more full MDC cycle. A write therefore shows 1 MDC rise with mdio_oe at 0, and a read shows 18.
- R10: busy rises in the clock after an accepted request and stays high until done. done is a single-cycle pulse, and busy is 0 in the cycle done is 1.
- R11: A request made while busy is ignored: the running frame's bits, timing and result are unchanged, and no extra done appears.
- R12: A write frame leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transaction when not busy |
| wr_en | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| half_div | input | 8 | MDC half period minus one, in system clocks |
| rdata | output | 16 | Last read result |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the controller with its default field widths, an 8-bit divider and a two-stage input synchroniser. It then varies half_div between 0, 1, 2, 3 and 6 across transactions. The zero setting makes MDC toggle every clock and stresses the shift logic at full rate. The larger settings give the synchroniser room, so that the acknowledge and read data land well before each sampling point. Two transactions send conflicting requests, including a new half_div, in the middle of a frame. This shows that the captured divider and the latched frame survive such requests.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_TURN,
    ST_DATA,
    ST_TAIL
  } seq_state_t;

  localparam logic [1:0] FRM_START = 2'b01;
  localparam logic [1:0] FRM_OP_WR = 2'b01;
  localparam logic [1:0] FRM_OP_RD = 2'b10;
  localparam logic [1:0] FRM_TA_WR = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      div_q <= div_in;
      cnt   <= '0;
    end else if (run) begin
      if (cnt == div_q) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == div_q);

  // R2: captured divider does not move during a frame
  p_div_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(div_q));
  // R2: phase counter never passes the captured limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= div_q));
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_i,
  input  logic              ack_stb,
  input  logic              bit_stb,
  input  logic              fin_stb,
  output logic [DATA_W-1:0] rdata
);
  logic              s_in;
  logic              ack_ok;
  logic [DATA_W-1:0] sh;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign s_in = mdio_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= SYNC_STAGES'({chain, mdio_i});
      end
      assign s_in = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_ok <= 1'b0;
      sh     <= '0;
      rdata  <= '0;
    end else begin
      if (ack_stb) ack_ok <= (s_in == 1'b0);
      if (bit_stb) sh <= {sh[DATA_W-2:0], s_in};
      if (fin_stb) rdata <= ack_ok ? sh : '1;
    end
  end

  // R12: result only moves at the end of a read
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !fin_stb |=> $stable(rdata));
  // R8: missing acknowledge yields all ones
  p_nack_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (fin_stb && !ack_ok) |=> (rdata == '1));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int RD_LEN  = 46,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_rd_in,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               tick,
  output logic               mdc,
  output logic               mdo,
  output logic               mdo_en,
  output logic               busy,
  output logic               done,
  output logic               ack_stb,
  output logic               bit_stb,
  output logic               fin_stb
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  seq_state_t         state;
  logic               half;
  logic               is_rd;
  logic [CNT_W-1:0]   left;
  logic [FRAME_W-1:0] shreg;

  assign ack_stb = tick && (state == ST_TURN) && half && is_rd;
  assign bit_stb = tick && (state == ST_DATA) && half;
  assign fin_stb = tick && (state == ST_TAIL) && half;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      half   <= 1'b0;
      is_rd  <= 1'b0;
      left   <= '0;
      shreg  <= '0;
      mdc    <= 1'b0;
      mdo    <= 1'b0;
      mdo_en <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            shreg  <= frame_in;
            left   <= is_rd_in ? CNT_W'(RD_LEN) : CNT_W'(FRAME_W);
            is_rd  <= is_rd_in;
            busy   <= 1'b1;
            mdo_en <= 1'b1;
            mdo    <= frame_in[FRAME_W-1];
            mdc    <= 1'b0;
            half   <= 1'b0;
            state  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!half) begin
              half <= 1'b1;
              mdc  <= 1'b1;
            end else if (left > CNT_W'(1)) begin
              shreg <= shreg << 1;
              mdo   <= shreg[FRAME_W-2];
              left  <= left - 1'b1;
              half  <= 1'b0;
              mdc   <= 1'b0;
            end else begin
              half  <= 1'b0;
              mdc   <= 1'b0;
              state <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            mdo_en <= 1'b0;
            mdo    <= 1'b0;
            state  <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (tick) begin
            if (!half) begin
              half <= 1'b1;
              mdc  <= 1'b1;
            end else begin
              half <= 1'b0;
              mdc  <= 1'b0;
              if (is_rd) begin
                left  <= CNT_W'(DATA_W);
                state <= ST_DATA;
              end else begin
                busy  <= 1'b0;
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (!half) begin
              half <= 1'b1;
              mdc  <= 1'b1;
            end else begin
              half <= 1'b0;
              mdc  <= 1'b0;
              if (left > CNT_W'(1)) left <= left - 1'b1;
              else                  state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (!half) begin
              half <= 1'b1;
              mdc  <= 1'b1;
            end else begin
              half  <= 1'b0;
              mdc   <= 1'b0;
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: driven bit is stable while MDC is high
  p_mdo_stable_high_r3: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> (mdo == $past(mdo)));
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11: frame kind is frozen while busy
  p_kind_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(is_rd));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_LEN     = 32,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DIV_W-1:0]  half_div,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int CMD_W   = 4 + 2 * ADDR_W;
  localparam int FRAME_W = PRE_LEN + CMD_W + 2 + DATA_W;
  localparam int RD_LEN  = PRE_LEN + CMD_W;

  logic               start;
  logic               tick;
  logic               ack_stb;
  logic               bit_stb;
  logic               fin_stb;
  logic [FRAME_W-1:0] frame;

  assign start = req && !busy;

  always_comb begin
    if (wr_en)
      frame = {{PRE_LEN{1'b1}}, FRM_START, FRM_OP_WR, phy_addr, reg_addr,
               FRM_TA_WR, wdata};
    else
      frame = {{PRE_LEN{1'b1}}, FRM_START, FRM_OP_RD, phy_addr, reg_addr,
               {(2 + DATA_W){1'b0}}};
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .run    (busy),
    .div_in (half_div),
    .tick   (tick)
  );

  mdio_frame_seq #(
    .FRAME_W (FRAME_W),
    .RD_LEN  (RD_LEN),
    .DATA_W  (DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .is_rd_in (!wr_en),
    .frame_in (frame),
    .tick     (tick),
    .mdc      (mdc),
    .mdo      (mdio_o),
    .mdo_en   (mdio_oe),
    .busy     (busy),
    .done     (done),
    .ack_stb  (ack_stb),
    .bit_stb  (bit_stb),
    .fin_stb  (fin_stb)
  );

  mdio_rx_capture #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .mdio_i  (mdio_i),
    .ack_stb (ack_stb),
    .bit_stb (bit_stb),
    .fin_stb (fin_stb),
    .rdata   (rdata)
  );

  // R10: done closes the busy window
  p_done_clears_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R9: nothing is driven and MDC rests low when idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  half_div = '0;
  logic [15:0] rdata;
  logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;

  always #4 clk = ~clk;

  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;
  logic        phy_armed = 1'b0;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_data = '0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master #(.DIV_W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .half_div(half_div), .rdata(rdata),
    .busy(busy), .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  typedef struct {
    bit          is_wr;
    logic [63:0] bits;
    int          nbits;
    int          tris;
    logic [15:0] rd;
    int          half;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails = 0;
  logic [15:0] last_rd = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // PHY model: answers reads after the master releases the line
  logic p_prev_oe = 1'b0, p_prev_mdc = 1'b0;
  int   p_cnt = 0;
  always @(negedge clk) begin
    if (phy_armed && p_prev_oe && !mdio_oe) begin
      phy_en  = 1'b1;
      phy_bit = phy_ack;
      p_cnt   = 0;
    end else if (phy_en && p_prev_mdc && !mdc) begin
      if (p_cnt < 16) begin
        phy_bit = phy_data[15 - p_cnt];
        p_cnt++;
      end else begin
        phy_en = 1'b0;
      end
    end
    p_prev_oe  = mdio_oe;
    p_prev_mdc = mdc;
  end

  // Monitor: collects the frame and compares at done
  int          cyc = 0, last_rise = 0, last_fall = 0, per = 0, rises = 0;
  int          cap_n = 0, tri_n = 0, hold_len = 0;
  logic [63:0] cap_bits = '0;
  logic        hold_bit = 1'b0;
  logic        m_prev_mdc = 1'b0, m_prev_oe = 1'b0, m_prev_mdo = 1'b0, m_prev_done = 1'b0;
  always @(negedge clk) begin
    exp_t        e;
    logic [63:0] pre;
    cyc++;
    if (!rst) begin
      if (mdc && !m_prev_mdc) begin
        if (rises == 1) per = cyc - last_rise;
        rises++;
        last_rise = cyc;
        if (mdio_oe) begin
          cap_bits = {cap_bits[62:0], mdio_o};
          cap_n++;
        end else tri_n++;
      end
      if (!mdc && m_prev_mdc && mdio_oe) last_fall = cyc;
      if (m_prev_oe && !mdio_oe && busy) begin
        hold_len = cyc - last_fall;
        hold_bit = m_prev_mdo;
      end
      if (done && m_prev_done) chk("R10 done width", 64'd2, 64'd1);
      if (done) begin
        if (q.size() == 0) begin
          chk("R11 unexpected done", 64'd1, 64'd0);
        end else begin
          e = q.pop_front();
          chk(e.is_wr ? "R4 bit count" : "R5 bit count", 64'(cap_n), 64'(e.nbits));
          chk(e.is_wr ? "R4 frame bits" : "R5 frame bits", cap_bits, e.bits);
          pre = cap_bits >> (e.nbits - 32);
          chk("R3 preamble", {32'd0, pre[31:0]}, 64'hFFFF_FFFF);
          chk("R9 released MDC rises", 64'(tri_n), 64'(e.tris));
          chk(e.is_wr ? "R12 rdata kept" : "R7/R8 rdata", {48'd0, rdata}, {48'd0, e.rd});
          chk("R2 MDC period", 64'(per), 64'(2 * e.half));
          chk("R6 hold length", 64'(hold_len), 64'(e.half));
          chk("R6 held bit", {63'd0, hold_bit}, {63'd0, e.bits[0]});
          chk("R10 busy low at done", {63'd0, busy}, 64'd0);
        end
        cap_bits = '0; cap_n = 0; tri_n = 0; rises = 0; per = 0;
        hold_len = 0; hold_bit = 1'b0;
      end
    end
    m_prev_mdc  = mdc;
    m_prev_oe   = mdio_oe;
    m_prev_mdo  = mdio_o;
    m_prev_done = done;
  end

  task automatic xfer(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd,
                      bit ack, logic [15:0] pd, int div, bit poke);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.is_wr = wr;
    e.half  = div + 1;
    if (wr) begin
      e.bits  = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
      e.nbits = 64;
      e.tris  = 1;
      e.rd    = last_rd;
    end else begin
      e.bits  = {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
      e.nbits = 46;
      e.tris  = 18;
      e.rd    = ack ? pd : 16'hFFFF;
      last_rd = e.rd;
    end
    phy_armed = !wr;
    phy_ack   = !ack;
    phy_data  = pd;
    q.push_back(e);
    req = 1'b1; wr_en = wr; phy_addr = pa; reg_addr = ra; wdata = wd;
    half_div = 8'(div);
    @(negedge clk);
    req = 1'b0;
    chk("R10 busy after accept", {63'd0, busy}, 64'd1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req = 1'b1; wr_en = !wr; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
      half_div = 8'd0;
      @(negedge clk);
      req = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk("R10 idle after done", {62'd0, busy, done}, 64'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {60'd0, busy, done, mdc, mdio_oe}, 64'd0);
    chk("R1 reset rdata", {48'd0, rdata}, 64'd0);
    xfer(1'b1, 5'h01, 5'h00, 16'hA55A, 1'b1, 16'h0000, 3, 1'b0);
    xfer(1'b0, 5'h1F, 5'h02, 16'h0000, 1'b1, 16'h1234, 3, 1'b0);
    xfer(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b0, 16'h0F0F, 2, 1'b0);
    xfer(1'b1, 5'h15, 5'h0A, 16'h0001, 1'b1, 16'h0000, 0, 1'b0);
    xfer(1'b0, 5'h0A, 5'h15, 16'h0000, 1'b1, 16'h8001, 6, 1'b1);
    xfer(1'b1, 5'h03, 5'h11, 16'hFFFF, 1'b1, 16'h0000, 1, 1'b1);
    xfer(1'b0, 5'h12, 5'h07, 16'h0000, 1'b1, 16'h0000, 3, 1'b0);
    repeat (40) @(negedge clk);
    chk("R11 no stray frame", {62'd0, busy, done}, 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=busy expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule